// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns raw 32-bit palette words, streamed in from memory over a valid/ready handshake, into a single internal colour form. Each internal entry is 25 bits wide: a transparency flag and 8 bits each of red, green and blue. The entries are written into a palette RAM that a pixel pipeline reads through a lookup port. A 2-bit format select chooses one of four input packings. A monochrome switch copies the low byte of the word into all three colour channels. The number of entries in one transfer follows the indexed colour depth that is currently selected.

Every accepted raw word is also kept in a 256-entry raw store. After a transfer has completed, the format select may change while the block is idle and not in the middle of a transfer. In that case the block converts the stored words again under the new format on its own, with no new fetch from memory. A one-cycle done pulse marks the last entry written, both for a transfer and for a re-conversion. Memory fetching and pixel rendering belong to neighbouring blocks.

Top module: `pal_convert`

## Requirements
- R1: Format select 0 takes red from bits [15:11], green from bits [10:5] and blue from bits [4:0], each shifted left to 8 bits. The transparency flag is always 0 in this format.
- R2: Format select 1 uses the same 5:6:5 layout as format 0 and takes the transparency flag from bit 24.
- R3: Format select 2 takes red from bits [23:18], green from bits [15:10] and blue from bits [7:2], each shifted left by 2. The transparency flag comes from bit 24.
- R4: Format select 3 takes red from bits [23:16], green from bits [15:8] and blue from bits [7:0]. The transparency flag comes from bit 24.
- R5: With monochrome on, red, green and blue all equal word bits [7:0] whatever the format. The transparency flag still follows the format.
- R6: The depth select sets the entry count: 1 gives 4 entries, 2 gives 16 and 3 gives 256. Words fill entries from 0 upward. Entries at or above the count keep their contents. The done output is high for exactly one cycle, in the cycle after the last word of a transfer is accepted.
- R7: With depth select 0 (non-indexed), words are accepted but no palette entry and no raw word is written, and done stays low. A format change in this depth starts no re-conversion.
- R8: When a transfer has completed before and the block is idle, a format select that differs from the one last used starts a re-conversion of the stored raw words. This covers entries 0 up to the count minus 1. The ready output is low while it runs, and done pulses once at its end.
- R9: A transfer converts all of its words under the format select seen with its first word. After such a transfer, a re-conversion follows only if the format select then differs from that captured value.
- R10: The lookup output carries the entry addressed by the lookup index one clock edge after the index is presented, {transparent, R, G, B} from the MSB down.
- R11: After reset the ready output is 1 and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Palette word packing select |
| mono_en | input | 1 | Monochrome override |
| depth_sel | input | 2 | Indexed depth: 0 none, 1 four, 2 sixteen, 3 256 entries |
| in_valid | input | 1 | Raw word valid |
| in_ready | output | 1 | Block can accept a raw word |
| in_word | input | 32 | Raw palette word |
| done | output | 1 | One-cycle pulse after the last entry is written |
| lk_idx | input | 8 | Lookup index |
| lk_data | output | 25 | Looked-up entry {transparent, R, G, B} |

## Verification
Two things can fall in the same clock edge: a change of format select, and a word handshake that either opens a transfer or continues one. The first case lets a format change and the first word of a transfer land on the same edge. The second case switches the format between later words of a transfer and switches it back before the last word. The bench then expects every entry under the format captured with the first word, ready to stay high after the transfer, and no second done pulse. The bench judges the palette through the lookup port, because a re-conversion started too early, or a capture made at the wrong edge, would show up as entries decoded in the wrong packing.

// File: rtl/pal_conv_pkg.sv
package pal_conv_pkg;

    localparam int WORD_W  = 32;
    localparam int CH_W    = 8;
    localparam int ENT_W   = 1 + 3 * CH_W;
    localparam int DEPTH_W = 2;

    typedef enum logic [1:0] {
        FMT_565  = 2'd0,
        FMT_565T = 2'd1,
        FMT_666T = 2'd2,
        FMT_888T = 2'd3
    } pal_fmt_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPARSE
    } seq_state_e;

    typedef struct packed {
        logic            t;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pal_entry_t;

    // Entry count for an indexed depth code; 0 for non-indexed.
    function automatic logic [8:0] entry_count(input logic [DEPTH_W-1:0] d);
        case (d)
            2'd1:    return 9'd4;
            2'd2:    return 9'd16;
            2'd3:    return 9'd256;
            default: return 9'd0;
        endcase
    endfunction

    function automatic pal_entry_t convert_word(input logic [WORD_W-1:0] w,
                                                input pal_fmt_e f,
                                                input logic mono);
        pal_entry_t e;
        e.t = (f == FMT_565) ? 1'b0 : w[24];
        case (f)
            FMT_565, FMT_565T: begin
                e.r = {w[15:11], 3'b000};
                e.g = {w[10:5],  2'b00};
                e.b = {w[4:0],   3'b000};
            end
            FMT_666T: begin
                e.r = {w[23:18], 2'b00};
                e.g = {w[15:10], 2'b00};
                e.b = {w[7:2],   2'b00};
            end
            default: begin
                e.r = w[23:16];
                e.g = w[15:8];
                e.b = w[7:0];
            end
        endcase
        if (mono) begin
            e.r = w[7:0];
            e.g = w[7:0];
            e.b = w[7:0];
        end
        return e;
    endfunction

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rd <= mem[ra];
    end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_conv_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         fmt_sel,
    input  logic               mono_en,
    input  logic [DEPTH_W-1:0] depth_sel,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               in_ready,
    output logic               done,
    output logic               raw_we,
    output logic [AW-1:0]      raw_wa,
    output logic [WORD_W-1:0]  raw_wd,
    output logic [AW-1:0]      raw_ra,
    input  logic [WORD_W-1:0]  raw_rd,
    output logic               pal_we,
    output logic [AW-1:0]      pal_wa,
    output pal_entry_t         pal_wd
);
    seq_state_e  state;
    pal_fmt_e    last_fmt;
    logic        have_raw;
    logic [AW:0] load_cnt;
    logic [AW:0] rd_cnt;
    logic        wv;
    logic [AW-1:0] wa;

    logic [AW:0] n;
    logic        indexed, accept, start_rp, rp_last;
    pal_fmt_e    cur_fmt, load_fmt;

    always_comb begin
        n        = entry_count(depth_sel);
        indexed  = (depth_sel != '0);
        cur_fmt  = pal_fmt_e'(fmt_sel);
        in_ready = (state == ST_IDLE);
        accept   = in_valid && in_ready;
        load_fmt = (load_cnt == '0) ? cur_fmt : last_fmt;
        start_rp = (state == ST_IDLE) && indexed && have_raw && (load_cnt == '0)
                   && !accept && (cur_fmt != last_fmt);
        rp_last  = wv && (({1'b0, wa} + 1'b1) >= n);

        raw_we = accept && indexed;
        raw_wa = load_cnt[AW-1:0];
        raw_wd = in_word;
        raw_ra = rd_cnt[AW-1:0];

        pal_we = raw_we || wv;
        pal_wa = wv ? wa : load_cnt[AW-1:0];
        pal_wd = wv ? convert_word(raw_rd, last_fmt, mono_en)
                    : convert_word(in_word, load_fmt, mono_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            last_fmt <= FMT_565;
            have_raw <= 1'b0;
            load_cnt <= '0;
            rd_cnt   <= '0;
            wv       <= 1'b0;
            wa       <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!indexed) begin
                        load_cnt <= '0;
                    end else if (accept) begin
                        if (load_cnt == '0) last_fmt <= cur_fmt;
                        if (load_cnt == n - 1'b1) begin
                            load_cnt <= '0;
                            done     <= 1'b1;
                            have_raw <= 1'b1;
                        end else begin
                            load_cnt <= load_cnt + 1'b1;
                        end
                    end else if (start_rp) begin
                        state    <= ST_REPARSE;
                        last_fmt <= cur_fmt;
                        rd_cnt   <= '0;
                        wv       <= 1'b0;
                    end
                end
                default: begin
                    if (rd_cnt < n) begin
                        wv     <= 1'b1;
                        wa     <= rd_cnt[AW-1:0];
                        rd_cnt <= rd_cnt + 1'b1;
                    end else begin
                        wv <= 1'b0;
                    end
                    if (rp_last) begin
                        state <= ST_IDLE;
                        wv    <= 1'b0;
                        done  <= 1'b1;
                    end else if (!indexed) begin
                        state <= ST_IDLE;
                        wv    <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pal_convert.sv
module pal_convert
    import pal_conv_pkg::*;
#(
    parameter int PAL_DEPTH = 256,
    localparam int AW       = $clog2(PAL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         fmt_sel,
    input  logic               mono_en,
    input  logic [DEPTH_W-1:0] depth_sel,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               done,
    input  logic [AW-1:0]      lk_idx,
    output logic [ENT_W-1:0]   lk_data
);
    logic              raw_we;
    logic [AW-1:0]     raw_wa, raw_ra;
    logic [WORD_W-1:0] raw_wd, raw_rd;
    logic              pal_we;
    logic [AW-1:0]     pal_wa;
    pal_entry_t        pal_wd;

    pal_seq #(.DEPTH(PAL_DEPTH)) seq_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .mono_en(mono_en),
        .depth_sel(depth_sel), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .done(done),
        .raw_we(raw_we), .raw_wa(raw_wa), .raw_wd(raw_wd),
        .raw_ra(raw_ra), .raw_rd(raw_rd),
        .pal_we(pal_we), .pal_wa(pal_wa), .pal_wd(pal_wd)
    );

    pal_ram #(.W(WORD_W), .DEPTH(PAL_DEPTH)) raw_store_i (
        .clk(clk), .we(raw_we), .wa(raw_wa), .wd(raw_wd),
        .ra(raw_ra), .rd(raw_rd)
    );

    pal_ram #(.W(ENT_W), .DEPTH(PAL_DEPTH)) pal_store_i (
        .clk(clk), .we(pal_we), .wa(pal_wa), .wd(pal_wd),
        .ra(lk_idx), .rd(lk_data)
    );
endmodule

// File: rtl/pal_convert_chk.sv
module pal_convert_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    depth_sel,
    input logic          mono_en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          done,
    input logic          raw_we,
    input logic [AW-1:0] raw_wa,
    input logic          pal_we,
    input logic [AW-1:0] pal_wa,
    input logic [24:0]   pal_wd
);
    // R7: a word taken in non-indexed depth touches neither store
    p_nonidx_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (depth_sel == 2'd0 && in_valid && in_ready) |-> (!raw_we && !pal_we));

    // R6: done lasts a single cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a word taken in an indexed depth lands at the same slot in both stores
    p_load_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (depth_sel != 2'd0 && in_valid && in_ready) |-> (raw_we && pal_we && raw_wa == pal_wa));

    // R8: palette writes without a handshake come from a re-conversion, which holds ready low
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (pal_we && !(in_valid && in_ready)) |-> !in_ready);

    // R5: monochrome entries carry equal channels
    p_mono_grey_r5: assert property (@(posedge clk) disable iff (rst)
        (pal_we && mono_en) |-> (pal_wd[23:16] == pal_wd[15:8] && pal_wd[15:8] == pal_wd[7:0]));
endmodule

bind pal_convert pal_convert_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .depth_sel(depth_sel), .mono_en(mono_en),
    .in_valid(in_valid), .in_ready(in_ready), .done(done),
    .raw_we(raw_we), .raw_wa(raw_wa), .pal_we(pal_we), .pal_wa(pal_wa),
    .pal_wd(pal_wd)
);

// File: tb/pal_convert_tb_top.sv
module pal_convert_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic        mono_en = 1'b0;
    logic [1:0]  depth_sel = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        done;
    logic [7:0]  lk_idx = '0;
    logic [24:0] lk_data;

    always #5 clk = ~clk;

    pal_convert dut_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .mono_en(mono_en),
        .depth_sel(depth_sel), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .done(done), .lk_idx(lk_idx), .lk_data(lk_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] model_raw [256];
    logic [24:0] model_pal [256];

    typedef struct {
        int          due;
        int          idx;
        logic [24:0] exp;
        string       tag;
    } probe_t;
    probe_t sbq [$];

    function automatic logic [24:0] exp_conv(input logic [31:0] w, input int f, input bit m);
        int r, g, b;
        bit t;
        t = (f == 0) ? 1'b0 : w[24];
        if (f <= 1) begin
            r = ((w >> 11) & 31) * 8;
            g = ((w >> 5) & 63) * 4;
            b = (w & 31) * 8;
        end else if (f == 2) begin
            r = ((w >> 18) & 63) * 4;
            g = ((w >> 10) & 63) * 4;
            b = ((w >> 2) & 63) * 4;
        end else begin
            r = (w >> 16) & 255;
            g = (w >> 8) & 255;
            b = w & 255;
        end
        if (m) begin
            r = w & 255;
            g = r;
            b = r;
        end
        return {t, r[7:0], g[7:0], b[7:0]};
    endfunction

    function automatic logic [31:0] gen(input int seed, input int i);
        logic [31:0] v;
        v = (32'h9E3779B9 * (i + 7 * seed + 1)) ^ (i << 13) ^ (seed << 27);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops scoreboard items when their lookup result is due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            probe_t p;
            p = sbq.pop_front();
            chk(lk_data == p.exp, p.tag, {7'd0, lk_data}, {7'd0, p.exp});
        end
    end

    // Driver: presents lookup indices back to back and queues expectations
    task automatic probe_range(input int lo, input int hi, input string tag);
        int step;
        step = (hi >= lo) ? 1 : -1;
        for (int i = lo; i != hi + step; i += step) begin
            probe_t p;
            @(posedge clk);
            #1;
            lk_idx = i[7:0];
            p.due = cyc + 1;
            p.idx = i;
            p.exp = model_pal[i];
            p.tag = tag;
            sbq.push_back(p);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input int f);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_word  = w;
        fmt_sel  = f[1:0];
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic int count_of(input logic [1:0] d);
        return (d == 2'd1) ? 4 : (d == 2'd2) ? 16 : (d == 2'd3) ? 256 : 0;
    endfunction

    task automatic load(input int seed, input int f);
        int n;
        n = count_of(depth_sel);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = gen(seed, i);
            model_raw[i] = w;
            model_pal[i] = exp_conv(w, f, mono_en);
            send_word(w, f);
        end
        @(negedge clk);
        chk(done == 1'b1, "R6 done after last word", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R6 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic wait_done(input string tag);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done == 1'b1, tag, {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(done == 1'b0, tag, {31'd0, done}, 32'd0);
    endtask

    task automatic set_fmt(input int f);
        int n;
        n = count_of(depth_sel);
        @(posedge clk);
        #1;
        fmt_sel = f[1:0];
        for (int i = 0; i < n; i++) model_pal[i] = exp_conv(model_raw[i], f, mono_en);
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R8 ready low during re-conversion", {31'd0, in_ready}, 32'd0);
        wait_done("R8 done after re-conversion");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(in_ready == 1'b1, "R11 ready after reset", {31'd0, in_ready}, 32'd1);
        chk(done == 1'b0, "R11 done after reset", {31'd0, done}, 32'd0);

        // R3 with the full 256-entry depth
        depth_sel = 2'd3;
        load(1, 2);
        probe_range(0, 255, "R3 format 2 entry");

        // R8: re-conversion of 256 stored words into format 3
        set_fmt(3);
        probe_range(0, 255, "R8 re-converted entry");

        // R4 with 16 entries; entries above stay
        depth_sel = 2'd2;
        load(2, 3);
        probe_range(0, 15, "R4 format 3 entry");
        probe_range(16, 20, "R6 entry above count kept");

        // R1 with 4 entries
        depth_sel = 2'd1;
        load(3, 0);
        probe_range(0, 3, "R1 format 0 entry");
        probe_range(4, 15, "R6 entry above count kept");
        probe_range(3, 0, "R10 lookup latency");

        // R2 by re-conversion; entries past the count untouched
        set_fmt(1);
        probe_range(0, 3, "R2 format 1 entry");
        probe_range(4, 7, "R8 re-conversion limited to count");

        // R5 monochrome under a transparent format, then format 0
        mono_en = 1'b1;
        load(4, 1);
        probe_range(0, 3, "R5 mono with format 1");
        set_fmt(0);
        probe_range(0, 3, "R5 mono with format 0");

        // R7 non-indexed depth
        @(posedge clk);
        #1 mono_en = 1'b0;
        depth_sel = 2'd0;
        for (int i = 0; i < 3; i++) begin
            send_word(32'hFFFF_FFFF - i, 0);
            @(negedge clk);
            chk(done == 1'b0, "R7 no done in non-indexed depth", {31'd0, done}, 32'd0);
        end
        @(posedge clk);
        #1 fmt_sel = 2'd2;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R7 no re-conversion in non-indexed depth", {31'd0, in_ready}, 32'd1);
        end
        @(posedge clk);
        #1 fmt_sel = 2'd0;
        depth_sel = 2'd1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R7 same format gives no re-conversion", {31'd0, in_ready}, 32'd1);
        end
        probe_range(0, 3, "R7 palette unchanged by non-indexed words");
        set_fmt(3);
        probe_range(0, 3, "R7 raw store unchanged by non-indexed words");

        // R9: format captured with the first word, altered mid-transfer
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            int f;
            w = gen(5, i);
            model_raw[i] = w;
            model_pal[i] = exp_conv(w, 1, 1'b0);
            f = (i == 0) ? 1 : (i == 1) ? 0 : (i == 2) ? 2 : 1;
            send_word(w, f);
        end
        @(negedge clk);
        chk(done == 1'b1, "R9 done after transfer", {31'd0, done}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1 && done == 1'b0, "R9 no re-conversion after transfer",
                {30'd0, in_ready, done}, 32'd2);
        end
        probe_range(0, 3, "R9 captured format entry");

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule